// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is a cycle-accurate digital model of the control logic that drives readout and reset in a linear image sensor with a parameterised pixel count (128 by default). It watches a serial start input. A rising edge on that input, seen on a clock edge while the block is idle, begins a readout frame. That same edge also produces a one-cycle hold strobe, which stands for the moment the sampling capacitors are disconnected from their integrators.

A single token then walks a chain of stages, one per pixel. The chain drives a one-hot pixel select and a binary pixel index. While the token is inside the chain, an output-enable is high, standing for the analog output being driven. One clock after the token reaches the last pixel, it drops out of the chain and the output-enable falls, which stands for high impedance. For the first clocks of the frame, the integrator reset enable is asserted. Integration of the next frame starts on the clock after that window.

A start edge that arrives while a frame is still running is ignored, and it sets a sticky protocol-error flag.

Top module: `sens_readout_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the clock edge clears the token chain, and afterwards `out_en`, `integ_active`, `proto_err`, `hold_strobe`, `integ_rst` and `pix_sel` are all 0.
- R2: A frame starts when `si` is sampled 1 on a clock edge, it was sampled 0 on the previous edge, and no frame is running. That edge is clock 1 of the frame. After clock 1, `pix_sel` equals 1 (bit 0 set), `pix_idx` is 0 and `out_en` is 1.
- R3: After clock n of a frame, for n from 1 to 128, `pix_sel` has exactly bit n-1 set, `pix_idx` equals n-1 and `out_en` is 1.
- R4: After clock 129 of a frame, the token has left the chain, so `pix_sel` is 0 and `out_en` is 0.
- R5: `hold_strobe` is 1 after clock 1 of a frame and 0 after every other clock.
- R6: `integ_rst` is 1 after clocks 1 through 18 of a frame and 0 from clock 19 onwards.
- R7: `integ_active` falls to 0 at clock 1 of a frame, rises to 1 at clock 19, and then stays at 1 until the next frame starts or a reset occurs.
- R8: A rising `si` edge sampled while a frame is running leaves the token's walk unchanged and sets `proto_err` to 1. `proto_err` stays at 1 until reset.
- R9: Holding `si` high across the end of a frame does not start a new frame. A fresh 0-to-1 transition is needed.
- R10: A rising `si` edge sampled on the clock right after clock 129 starts a new frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| si | input | 1 | Serial start input |
| pix_sel | output | 128 | One-hot pixel select from the token chain |
| pix_idx | output | 7 | Binary index of the selected pixel |
| hold_strobe | output | 1 | One-cycle capacitor-disconnect pulse |
| integ_rst | output | 1 | Integrator reset enable |
| out_en | output | 1 | Output driven (1) or high impedance (0) |
| integ_active | output | 1 | Integration in progress |
| proto_err | output | 1 | Sticky flag for a start edge during a frame |

## Verification
The bench targets the edges of the reset window at clocks 18 and 19. A design with an off-by-one error there would release the integrators a clock early or late, and would move the rise of `integ_active` with it. It checks clocks 128 and 129, where a design that dropped the terminating clock would turn the output off while the last pixel was still selected, or would hold it on one clock too long. Further tests cover a second start during a frame, a start held high through the end of a frame, and a start on the very first idle clock. A design that restarted on any level, or that did not flag the second start, would corrupt the token walk or leave `proto_err` clear.

// File: rtl/sens_pkg.sv
package sens_pkg;

  // true when the frame clock count lies inside the integrator reset window
  function automatic logic in_reset_window(input int unsigned clk_no,
                                           input int unsigned win_len);
    return (clk_no >= 1) && (clk_no <= win_len);
  endfunction

  // clock number of the frame on which integration restarts
  function automatic int unsigned integ_start_clk(input int unsigned win_len);
    return win_len + 1;
  endfunction

  // clock number of the frame on which the token leaves the chain
  function automatic int unsigned exit_clk(input int unsigned npix);
    return npix + 1;
  endfunction

endpackage

// File: rtl/sens_start_detect.sv
module sens_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic si,
  input  logic busy,
  output logic start,
  output logic si_rise,
  output logic proto_err
);
  logic si_prev;

  assign si_rise = si && !si_prev;
  assign start   = si_rise && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      si_prev   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      si_prev <= si;
      if (si_rise && busy) proto_err <= 1'b1;
    end
  end

  // R8: an edge during a frame must leave the flag set
  assert_err_on_busy_edge_R8: assert property (@(posedge clk) disable iff (rst)
    (si_rise && busy) |=> proto_err);

  // R8: flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  // R9: a level held high never starts twice
  assert_no_level_start_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
endmodule

// File: rtl/sens_token_chain.sv
module sens_token_chain #(
  parameter int NPIX = 128,
  localparam int IW = $clog2(NPIX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic [NPIX-1:0] token,
  output logic [IW-1:0]   idx,
  output logic            busy
);
  function automatic logic [IW-1:0] onehot_to_idx(input logic [NPIX-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NPIX; i++)
      if (v[i]) r = r | IW'(i);
    return r;
  endfunction

  for (genvar g = 0; g < NPIX; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) token[g] <= 1'b0;
      else if (g == 0) token[g] <= start;
      else token[g] <= token[(g == 0) ? 0 : g-1];
    end
  end

  assign busy = |token;
  assign idx  = onehot_to_idx(token);

  // R3: only one token at any time
  assert_single_token_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(token));

  // R3: token advances exactly one stage per clock
  assert_token_walk_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !token[NPIX-1]) |=> (token == ($past(token) << 1)));

  // R4: token leaves the chain after the last stage
  assert_token_exit_R4: assert property (@(posedge clk) disable iff (rst)
    token[NPIX-1] |=> !busy);
endmodule

// File: rtl/sens_phase_timer.sv
module sens_phase_timer
  import sens_pkg::*;
#(
  parameter int NPIX     = 128,
  parameter int RST_CLKS = 18,
  localparam int CW = $clog2(NPIX + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic hold_strobe,
  output logic integ_rst,
  output logic integ_active,
  output logic frame_live
);
  logic [CW-1:0] clk_no;  // clock number of the current frame, 0 when idle

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_no       <= '0;
      integ_active <= 1'b0;
    end else begin
      if (start) clk_no <= CW'(1);
      else if (clk_no == CW'(NPIX)) clk_no <= '0;
      else if (clk_no != '0) clk_no <= clk_no + CW'(1);

      if (start) integ_active <= 1'b0;
      else if (int'(clk_no) + 1 == int'(integ_start_clk(RST_CLKS))) integ_active <= 1'b1;
    end
  end

  assign frame_live  = (clk_no != '0);
  assign hold_strobe = (clk_no == CW'(1));
  assign integ_rst   = in_reset_window(int'(clk_no), RST_CLKS);

  // R5: hold strobe lasts one cycle
  assert_hold_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    hold_strobe |=> !hold_strobe);

  // R6: the window begins together with the hold strobe
  assert_reset_with_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_strobe) |-> integ_rst);

  // R7: integration begins exactly when reset releases
  assert_integ_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(integ_rst) |-> integ_active);
endmodule

// File: rtl/sens_readout_seq.sv
module sens_readout_seq #(
  parameter int NPIX     = 128,
  parameter int RST_CLKS = 18,
  localparam int IW = $clog2(NPIX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            si,
  output logic [NPIX-1:0] pix_sel,
  output logic [IW-1:0]   pix_idx,
  output logic            hold_strobe,
  output logic            integ_rst,
  output logic            out_en,
  output logic            integ_active,
  output logic            proto_err
);
  logic start_evt;
  logic si_rise_evt;
  logic chain_busy;
  logic timer_live;

  sens_start_detect u_start (
    .clk       (clk),
    .rst       (rst),
    .si        (si),
    .busy      (chain_busy),
    .start     (start_evt),
    .si_rise   (si_rise_evt),
    .proto_err (proto_err)
  );

  sens_token_chain #(.NPIX(NPIX)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .start (start_evt),
    .token (pix_sel),
    .idx   (pix_idx),
    .busy  (chain_busy)
  );

  sens_phase_timer #(.NPIX(NPIX), .RST_CLKS(RST_CLKS)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .start        (start_evt),
    .hold_strobe  (hold_strobe),
    .integ_rst    (integ_rst),
    .integ_active (integ_active),
    .frame_live   (timer_live)
  );

  assign out_en = chain_busy;

  // R1: reset returns every flag to idle
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_en && !integ_active && !proto_err && !hold_strobe));

  // R2: start puts token in stage 0 with hold
  assert_start_stage0_R2: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (pix_sel[0] && hold_strobe && out_en));

  // R4: chain and timer agree on frame extent
  assert_phase_align_R4: assert property (@(posedge clk) disable iff (rst)
    out_en == timer_live);
endmodule

// File: tb/sens_readout_seq_tb.sv
module sens_readout_seq_tb;
  localparam int NPIX = 128;
  localparam int NV = 12;
  // fields: [19:12] clock no, [11] out_en, [10] hold, [9] integ_rst, [8] integ_active, [6:0] idx
  localparam logic [19:0] VEC [NV] = '{
    {8'd1,   4'b1110, 1'b0, 7'd0},
    {8'd2,   4'b1010, 1'b0, 7'd1},
    {8'd3,   4'b1010, 1'b0, 7'd2},
    {8'd17,  4'b1010, 1'b0, 7'd16},
    {8'd18,  4'b1010, 1'b0, 7'd17},
    {8'd19,  4'b1001, 1'b0, 7'd18},
    {8'd20,  4'b1001, 1'b0, 7'd19},
    {8'd64,  4'b1001, 1'b0, 7'd63},
    {8'd100, 4'b1001, 1'b0, 7'd99},
    {8'd127, 4'b1001, 1'b0, 7'd126},
    {8'd128, 4'b1001, 1'b0, 7'd127},
    {8'd129, 4'b0001, 1'b0, 7'd0}
  };

  logic clk = 0, rst = 1, si = 0;
  logic [NPIX-1:0] pix_sel;
  logic [6:0] pix_idx;
  logic hold_strobe, integ_rst, out_en, integ_active, proto_err;
  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sens_readout_seq u_dut (
    .clk(clk), .rst(rst), .si(si), .pix_sel(pix_sel), .pix_idx(pix_idx),
    .hold_strobe(hold_strobe), .integ_rst(integ_rst), .out_en(out_en),
    .integ_active(integ_active), .proto_err(proto_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_frame_point(input int n);
    for (int v = 0; v < NV; v++) begin
      if (int'(VEC[v][19:12]) == n) begin
        chk("R3 out_en", 128'(out_en), 128'(VEC[v][11]));
        chk("R5 hold_strobe", 128'(hold_strobe), 128'(VEC[v][10]));
        chk("R6 integ_rst", 128'(integ_rst), 128'(VEC[v][9]));
        chk("R7 integ_active", 128'(integ_active), 128'(VEC[v][8]));
        if (VEC[v][11]) begin
          chk("R3 pix_idx", 128'(pix_idx), 128'(VEC[v][6:0]));
          chk("R3 pix_sel", 128'(pix_sel), 128'(1) << VEC[v][6:0]);
        end else begin
          chk("R4 pix_sel", 128'(pix_sel), 128'(0));
        end
      end
    end
  endtask

  // one frame: si pulsed for one clock, table checked up to clock 129
  task automatic run_frame();
    si = 1;
    for (int n = 1; n <= 129; n++) begin
      tick();
      if (n == 1) si = 0;
      chk_frame_point(n);
    end
  endtask

  initial begin
    // R1: reset state
    si = 1;
    repeat (3) tick();
    chk("R1 out_en", 128'(out_en), 128'(0));
    chk("R1 pix_sel", 128'(pix_sel), 128'(0));
    chk("R1 integ_active", 128'(integ_active), 128'(0));
    chk("R1 proto_err", 128'(proto_err), 128'(0));
    chk("R1 integ_rst", 128'(integ_rst), 128'(0));
    rst = 0; si = 0;
    tick();

    // R2..R7: table walk over two frames
    run_frame();
    tick();
    run_frame();

    // R10: start right after clock 129 of the previous frame
    si = 1;
    tick();
    si = 0;
    chk("R10 out_en", 128'(out_en), 128'(1));
    chk("R10 pix_idx", 128'(pix_idx), 128'(0));
    chk("R7 integ_active cleared at start", 128'(integ_active), 128'(0));
    chk("R2 hold_strobe", 128'(hold_strobe), 128'(1));
    repeat (130) tick();
    chk("R4 idle", 128'(out_en), 128'(0));

    // R9: si held high across frame end
    si = 1;
    tick();
    chk("R9 started", 128'(out_en), 128'(1));
    repeat (140) tick();
    chk("R9 no restart on level", 128'(out_en), 128'(0));
    chk("R9 no error on level", 128'(proto_err), 128'(0));
    si = 0;
    tick();
    si = 1;
    tick();
    chk("R9 fresh edge starts", 128'(out_en), 128'(1));
    chk("R9 fresh edge idx", 128'(pix_idx), 128'(0));
    si = 0;

    // R8: second edge during a frame
    repeat (48) tick();   // now after clock 49
    chk("R8 before edge idx", 128'(pix_idx), 128'(48));
    si = 1;
    tick();
    si = 0;
    chk("R8 proto_err set", 128'(proto_err), 128'(1));
    chk("R8 walk unchanged", 128'(pix_idx), 128'(49));
    chk("R8 no hold on ignored edge", 128'(hold_strobe), 128'(0));
    tick();
    chk("R8 walk continues", 128'(pix_sel), 128'(1) << 50);
    repeat (100) tick();
    chk("R8 proto_err sticky", 128'(proto_err), 128'(1));

    // R1: reset mid-frame
    si = 1;
    tick();
    si = 0;
    repeat (30) tick();
    chk("R7 active mid frame", 128'(integ_active), 128'(1));
    rst = 1;
    tick();
    chk("R1 mid-frame out_en", 128'(out_en), 128'(0));
    chk("R1 mid-frame integ_active", 128'(integ_active), 128'(0));
    chk("R1 mid-frame proto_err", 128'(proto_err), 128'(0));
    chk("R1 mid-frame pix_sel", 128'(pix_sel), 128'(0));
    rst = 0;
    tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule